// File: doc/BRIEF.md
# Bus Area Decoder with Wait-State Generator

This block sits between a CPU's physical address bus and a set of external static memories. On each accepted request it looks at three address bits to pick one of three memory areas, drives that area's active-low chip select, and drives either the read strobe or the byte-lane write strobes. It holds these outputs for one base cycle plus a programmed number of wait cycles. The programmed count comes from a wait-select field that the block samples when it accepts the request.

After the programmed count runs out, an external active-low wait pin can stretch the access further, with no limit. The pin passes through a two-flop synchronizer first. An address that selects no implemented area finishes at once with an error flag and drives no strobe. The byte lanes written depend on the access size, the low address bits and the data-bus width of the selected area. Area 0 takes its width from mode inputs captured during reset. Areas 1 and 2 take their widths from configuration inputs.

Top module: `bus_area_ctrl`

## Requirements
- R1: Address bits 28..26 choose the area: 000 drives csN[0] low, 001 drives csN[1] low, 010 drives csN[2] low. Address bits 31..29 have no effect on the choice.
- R2: When bits 28..26 are 011 through 111, no chip select goes low. ack and err are both high for exactly one cycle, in the cycle after acceptance.
- R3: For area 0, a0WaitSel values 0..7 insert 0, 1, 2, 3, 4, 6, 8 and 10 wait cycles. A chip select stays low for 1 + waits cycles when the wait pin is idle.
- R4: For areas 1 and 2, the shared a12WaitSel field inserts 0..3 wait cycles, equal to its value.
- R5: extWaitN reaches the control two clock edges after the pin changes. Suppose the request is accepted at edge 0, the pin is already low, and the pin is released before edge r. The chip select then stays low for 1 + max(waits, r+1) cycles.
- R6: During a read, rdN is low in every cycle the chip select is low, and all weN stay high. During a write, rdN stays high.
- R7: During a write, weN[i] is low exactly for byte lane i. Width and size codes are 00 byte, 01 word, 1x longword. On a byte bus only lane 0 is written. On a word bus, a byte access writes lane addr[0], and a word or longword access writes lanes 0 and 1. On a longword bus, a byte access writes lane addr[1:0], a word access writes lanes 0-1 or 2-3 by addr[1], and a longword access writes all four lanes.
- R8: Area 0's bus width is the value on modeWidth during reset. Changes on modeWidth after reset have no effect.
- R9: ack is high only in the last cycle of an access and lasts one cycle. In the following cycle all chip selects are high.
- R10: reqValid is ignored while an access is in progress and produces no further access.
- R11: During reset, csN, rdN and weN are all high, and ack and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqAddr | input | 32 | Physical address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access size: 00 byte, 01 word, 1x longword |
| a0WaitSel | input | 3 | Area 0 wait-select code |
| a12WaitSel | input | 2 | Shared wait count for areas 1 and 2 |
| a1Width | input | 2 | Area 1 bus width |
| a2Width | input | 2 | Area 2 bus width |
| modeWidth | input | 2 | Area 0 bus width, captured during reset |
| extWaitN | input | 1 | External wait request, active low, asynchronous |
| csN | output | 3 | Area chip selects, active low |
| rdN | output | 1 | Read strobe / output enable, active low |
| weN | output | 4 | Byte-lane write enables, active low |
| ack | output | 1 | Access completion to the CPU |
| err | output | 1 | Completion without a decoded area |

## Verification
The embedded assertions check the properties that hold in every cycle. At most one chip select is low at a time. Read and write strobes never overlap, and neither appears without a chip select. The chip select holds steady until ack. err always comes with ack. ack lasts one cycle, and an access with a nonzero count cannot end early. Only the bench scenarios can show that the access length matches each wait code, that shadow addresses alias, that the lane mask is right for each width and size, that a late release of the wait pin lengthens the access by the right amount, that area 0 keeps its width from reset, and that requests during a busy access are ignored.

// File: rtl/busarea_pkg.sv
package busarea_pkg;

  localparam int LANE_CNT = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FAULT  = 2'd2
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture the request this cycle
    logic active;  // an access is on the bus
  } ctlStrb_t;

  // area 0 wait code -> inserted wait cycles
  function automatic logic [3:0] area0WaitMap(input logic [2:0] sel);
    logic [3:0] w;
    case (sel)
      3'd5:    w = 4'd6;
      3'd6:    w = 4'd8;
      3'd7:    w = 4'd10;
      default: w = {1'b0, sel};
    endcase
    return w;
  endfunction

  // byte lanes touched by a write; width/size: 00 byte, 01 word, 1x long
  function automatic logic [LANE_CNT-1:0] laneMask(input logic [1:0] busW,
                                                   input logic [1:0] sizeSel,
                                                   input logic [1:0] lowAddr);
    logic [LANE_CNT-1:0] m;
    if (busW == 2'b00) begin
      m = 4'b0001;
    end else if (busW == 2'b01) begin
      if (sizeSel == 2'b00) m = lowAddr[0] ? 4'b0010 : 4'b0001;
      else                  m = 4'b0011;
    end else begin
      if (sizeSel == 2'b00)      m = 4'b0001 << lowAddr;
      else if (sizeSel == 2'b01) m = lowAddr[1] ? 4'b1100 : 4'b0011;
      else                       m = 4'b1111;
    end
    return m;
  endfunction

endpackage

// File: rtl/busarea_dp.sv
module busarea_dp
  import busarea_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SEL_LO   = 26,
  parameter int SEL_W    = 3,
  parameter int AREA_CNT = 3,
  parameter int WAIT_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic [1:0]          reqSize,
  input  logic [2:0]          a0WaitSel,
  input  logic [1:0]          a12WaitSel,
  input  logic [1:0]          a1Width,
  input  logic [1:0]          a2Width,
  input  logic [1:0]          modeWidth,
  input  ctlStrb_t            strb,
  output logic                reqHit,
  output logic [WAIT_W-1:0]   reqWaits,
  output logic [AREA_CNT-1:0] csN,
  output logic                rdN,
  output logic [LANE_CNT-1:0] weN
);

  logic [SEL_W-1:0]    areaSel;
  logic [1:0]          a0WidthQ;
  logic [1:0]          busW;
  logic [SEL_W-1:0]    areaQ;
  logic                writeQ;
  logic [LANE_CNT-1:0] maskQ;

  assign areaSel = reqAddr[SEL_LO +: SEL_W];
  assign reqHit  = (areaSel < SEL_W'(AREA_CNT));

  always_comb begin
    if (areaSel == '0) reqWaits = WAIT_W'(area0WaitMap(a0WaitSel));
    else               reqWaits = WAIT_W'(a12WaitSel);
  end

  always_comb begin
    case (areaSel)
      SEL_W'(0): busW = a0WidthQ;
      SEL_W'(1): busW = a1Width;
      default:   busW = a2Width;
    endcase
  end

  // area 0 width follows the mode pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) a0WidthQ <= modeWidth;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      areaQ  <= '0;
      writeQ <= 1'b0;
      maskQ  <= '0;
    end else if (strb.load && reqHit) begin
      areaQ  <= areaSel;
      writeQ <= reqWrite;
      maskQ  <= laneMask(busW, reqSize, reqAddr[1:0]);
    end
  end

  for (genvar k = 0; k < AREA_CNT; k++) begin : g_cs
    assign csN[k] = ~(strb.active && (areaQ == SEL_W'(k)));
  end

  assign rdN = ~(strb.active && !writeQ);
  assign weN = (strb.active && writeQ) ? ~maskQ : '1;

  // R1
  cs_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  // R6
  rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && (weN != '1)));
  // R2
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || (weN != '1)) |-> (csN != '1));

endmodule

// File: rtl/busarea_ctl.sv
module busarea_ctl
  import busarea_pkg::*;
#(
  parameter int WAIT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqHit,
  input  logic [WAIT_W-1:0] reqWaits,
  input  logic              extWaitN,
  output ctlStrb_t          strb,
  output logic              ack,
  output logic              err
);

  busState_e             state;
  logic [WAIT_W-1:0]     waitCnt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                  waitHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], extWaitN};
  end
  assign waitHeld = ~syncQ[SYNC_STAGES-1];

  always_comb begin
    strb.load   = (state == ST_IDLE) && reqValid;
    strb.active = (state == ST_ACCESS);
    err         = (state == ST_FAULT);
    ack         = err || (strb.active && (waitCnt == '0) && !waitHeld);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          if (reqHit) begin
            state   <= ST_ACCESS;
            waitCnt <= reqWaits;
          end else begin
            state <= ST_FAULT;
          end
        end
        ST_ACCESS: begin
          if (waitCnt != '0)  waitCnt <= waitCnt - WAIT_W'(1);
          else if (!waitHeld) state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  err_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> ack);
  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);
  // R3
  count_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && waitCnt != '0) |=> strb.active);
  // R5
  wait_extends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !ack) |=> strb.active);

endmodule

// File: rtl/bus_area_ctrl.sv
module bus_area_ctrl
  import busarea_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SEL_LO      = 26,
  parameter int SEL_W       = 3,
  parameter int AREA_CNT    = 3,
  parameter int WAIT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic [1:0]          reqSize,
  input  logic [2:0]          a0WaitSel,
  input  logic [1:0]          a12WaitSel,
  input  logic [1:0]          a1Width,
  input  logic [1:0]          a2Width,
  input  logic [1:0]          modeWidth,
  input  logic                extWaitN,
  output logic [AREA_CNT-1:0] csN,
  output logic                rdN,
  output logic [LANE_CNT-1:0] weN,
  output logic                ack,
  output logic                err
);

  ctlStrb_t          strb;
  logic              reqHit;
  logic [WAIT_W-1:0] reqWaits;

  busarea_ctl #(.WAIT_W(WAIT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHit(reqHit),
    .reqWaits(reqWaits), .extWaitN(extWaitN), .strb(strb),
    .ack(ack), .err(err)
  );

  busarea_dp #(.ADDR_W(ADDR_W), .SEL_LO(SEL_LO), .SEL_W(SEL_W),
               .AREA_CNT(AREA_CNT), .WAIT_W(WAIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqSize(reqSize), .a0WaitSel(a0WaitSel), .a12WaitSel(a12WaitSel),
    .a1Width(a1Width), .a2Width(a2Width), .modeWidth(modeWidth),
    .strb(strb), .reqHit(reqHit), .reqWaits(reqWaits),
    .csN(csN), .rdN(rdN), .weN(weN)
  );

  // R1
  csn_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((csN != '1) && !ack) |=> $stable(csN));

endmodule

// File: tb/bus_area_ctrl_tb.sv
module bus_area_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'b00;
  logic [2:0]  a0WaitSel = '0;
  logic [1:0]  a12WaitSel = '0;
  logic [1:0]  a1Width = 2'b10;
  logic [1:0]  a2Width = 2'b01;
  logic [1:0]  modeWidth = 2'b10;
  logic        extWaitN = 1'b1;
  logic [2:0]  csN;
  logic        rdN;
  logic [3:0]  weN;
  logic        ack;
  logic        err;

  int errors = 0;
  int checks = 0;
  int doneCnt = 0;

  typedef struct {
    int         area;
    bit         isErr;
    bit         isRead;
    logic [3:0] weMask;
    int         len;
    string      lenTag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  bus_area_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSize(reqSize), .a0WaitSel(a0WaitSel),
    .a12WaitSel(a12WaitSel), .a1Width(a1Width), .a2Width(a2Width),
    .modeWidth(modeWidth), .extWaitN(extWaitN), .csN(csN), .rdN(rdN),
    .weN(weN), .ack(ack), .err(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int waitsFor(input logic [2:0] a0s, input logic [1:0] a12s,
                                  input int area);
    int t[8] = '{0, 1, 2, 3, 4, 6, 8, 10};
    if (area == 0) return t[a0s];
    return int'(a12s);
  endfunction

  task automatic doReset(input logic [1:0] mode);
    @(negedge clk);
    rstN = 1'b0;
    modeWidth = mode;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // relEdge: 0 = wait pin idle; else pin low before acceptance, released before edge relEdge
  // glitchAt: 0 = none; else a second request pulse that many cycles into the access
  task automatic runAccess(input logic [31:0] addr, input bit wr, input logic [1:0] sz,
                           input logic [2:0] a0s, input logic [1:0] a12s,
                           input int relEdge, input int glitchAt,
                           input logic [3:0] expMask, input string tag);
    expItem_t it;
    int area;
    int w;
    int tgt;
    area = int'(addr[28:26]);
    w = waitsFor(a0s, a12s, area);
    it.area   = (area > 2) ? 3 : area;
    it.isErr  = (area > 2);
    it.isRead = (area <= 2) && !wr;
    it.weMask = (area <= 2 && wr) ? expMask : 4'b0000;
    if (area > 2)        it.len = 1;
    else if (relEdge > 0) it.len = 1 + ((w > relEdge + 1) ? w : relEdge + 1);
    else                 it.len = 1 + w;
    it.lenTag = tag;
    @(negedge clk);
    reqAddr = addr; reqWrite = wr; reqSize = sz;
    a0WaitSel = a0s; a12WaitSel = a12s;
    if (relEdge > 0) extWaitN = 1'b0;
    repeat (2) @(negedge clk);
    tgt = doneCnt + 1;
    expQ.push_back(it);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (relEdge > 0) begin
      repeat (relEdge - 1) @(negedge clk);
      extWaitN = 1'b1;
    end
    if (glitchAt > 0) begin
      repeat (glitchAt - 1) @(negedge clk);
      reqAddr = 32'h0800_0000; reqWrite = 1'b1; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (doneCnt < tgt) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  bit         inAcc = 0;
  bit         postAck = 0;
  int         len = 0;
  logic [2:0] obsCs;
  bit         obsRd;
  logic [3:0] obsWe;

  always @(negedge clk) begin
    if (!rstN) begin
      inAcc = 0;
      postAck = 0;
    end else begin
      if (postAck) begin
        // R9: one-cycle ack, bus idle right after
        check(csN == 3'b111 && !ack, "R9", "idle after ack", int'({csN, ack}), 32'b1110);
        postAck = 0;
      end
      if (csN != 3'b111 || ack) begin
        if (!inAcc) begin
          inAcc = 1; len = 0;
          obsCs = csN; obsRd = !rdN; obsWe = ~weN;
        end
        len++;
        if (ack) begin
          int obsArea;
          expItem_t e;
          obsArea = (obsCs == 3'b110) ? 0 : (obsCs == 3'b101) ? 1 :
                    (obsCs == 3'b011) ? 2 : 3;
          if (expQ.size() == 0) begin
            check(0, "R10", "unexpected completion", 1, 0);
          end else begin
            e = expQ.pop_front();
            check(obsArea == e.area, e.isErr ? "R2" : "R1", "area", obsArea, e.area);
            check(err == e.isErr, "R2", "err flag", int'(err), int'(e.isErr));
            check(obsRd == e.isRead, "R6", "read strobe", int'(obsRd), int'(e.isRead));
            check(obsWe == e.weMask, "R7", "write lanes", int'(obsWe), int'(e.weMask));
            check(len == e.len, e.lenTag, "access length", len, e.len);
          end
          inAcc = 0;
          postAck = 1;
          doneCnt++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    modeWidth = 2'b10;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(csN == 3'b111, "R11", "csN in reset", int'(csN), 7);
    check(rdN && weN == 4'b1111, "R11", "strobes in reset", int'({rdN, weN}), 31);
    check(!ack && !err, "R11", "ack/err in reset", int'({ack, err}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // area 0 (longword bus) wait codes, shadow aliasing
    runAccess(32'h0000_1000, 0, 2'b10, 3'd0, 2'd0, 0, 0, 4'b0000, "R3");
    runAccess(32'h2000_0010, 0, 2'b10, 3'd5, 2'd0, 0, 0, 4'b0000, "R3");
    runAccess(32'hC000_0000, 1, 2'b10, 3'd7, 2'd0, 0, 0, 4'b1111, "R3");
    runAccess(32'h0000_0004, 0, 2'b00, 3'd3, 2'd0, 0, 0, 4'b0000, "R3");
    // area 1 (longword bus)
    runAccess(32'h0400_0003, 1, 2'b00, 3'd0, 2'd2, 0, 0, 4'b1000, "R4");
    runAccess(32'h6400_0000, 0, 2'b10, 3'd0, 2'd3, 0, 0, 4'b0000, "R4");
    runAccess(32'h0400_0002, 1, 2'b01, 3'd0, 2'd0, 0, 0, 4'b1100, "R4");
    // area 2 (word bus)
    runAccess(32'h0800_0002, 1, 2'b01, 3'd0, 2'd1, 0, 0, 4'b0011, "R4");
    runAccess(32'h4800_0001, 1, 2'b00, 3'd0, 2'd0, 0, 0, 4'b0010, "R4");
    // undecoded areas
    runAccess(32'h0C00_0000, 0, 2'b10, 3'd0, 2'd0, 0, 0, 4'b0000, "R2");
    runAccess(32'h1C00_0000, 1, 2'b10, 3'd7, 2'd3, 0, 0, 4'b0000, "R2");
    // external wait
    runAccess(32'h0000_0000, 0, 2'b10, 3'd2, 2'd0, 5, 0, 4'b0000, "R5");
    runAccess(32'h0000_0000, 0, 2'b10, 3'd4, 2'd0, 1, 0, 4'b0000, "R5");
    runAccess(32'h0400_0000, 1, 2'b10, 3'd0, 2'd0, 3, 0, 4'b1111, "R5");
    // request during a busy access
    runAccess(32'h0000_0100, 0, 2'b10, 3'd7, 2'd0, 0, 3, 4'b0000, "R10");
    check(expQ.size() == 0, "R10", "pending after busy pulse", expQ.size(), 0);

    // area 0 width from reset: word bus, later pin change ignored
    doReset(2'b01);
    modeWidth = 2'b00;
    runAccess(32'h0000_0001, 1, 2'b00, 3'd0, 2'd0, 0, 0, 4'b0010, "R8");
    runAccess(32'h0000_0000, 1, 2'b10, 3'd1, 2'd0, 0, 0, 4'b0011, "R8");
    // byte bus
    doReset(2'b00);
    modeWidth = 2'b10;
    runAccess(32'h0000_0003, 1, 2'b10, 3'd0, 2'd0, 0, 0, 4'b0001, "R8");

    check(expQ.size() == 0, "R10", "leftover items", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule